// File: doc/BRIEF.md
# Processor Memory-Map Decoder with Calibration Write Guard

This block sits between an 8-bit processor's 16-bit address bus and two memories: a program ROM and a data RAM. From the address, the read/write line and the bus clock phase it raises a chip enable for whichever memory owns the address. It also drives an active-low read strobe during the high half of the phase and an active-low RAM write strobe during the low half. Addresses 0x2000-0xFFFF belong to the ROM, 0x0040-0x1FFF to the RAM, and 0x0000-0x003F to neither.

The bottom of RAM, 0x0040-0x01FF, holds calibration constants. A write there reaches the RAM only while the unlock input is high. When the unlock input is low, the write strobe stays inactive and a registered violation flag pulses for one system clock. The flag comes from a three-state guard machine: `G_IDLE`, `G_FLAG` and `G_HOLD`. It has these transitions:
- `G_IDLE -> G_FLAG` on a blocked write.
- `G_FLAG -> G_HOLD` while that write persists.
- `G_FLAG -> G_IDLE` once it ends.
- `G_HOLD -> G_IDLE` once it ends.

Every other output is purely combinational.

Top module: `memmap_decoder`

## Requirements
- R1: `rom_ce` is high exactly when any of address bits 15..13 is high (0x2000-0xFFFF).
- R2: `ram_ce` is high exactly when address bits 15..13 are all low and any of bits 12..6 is high (0x0040-0x1FFF). `rom_ce` and `ram_ce` are never high together.
- R3: Addresses 0x0000-0x003F raise neither chip enable and never produce a write strobe.
- R4: `rd_n` is low exactly when `phase` is high and `rd_nwr` is high (1 = read, 0 = write), whatever the address.
- R5: For RAM addresses with any of bits 12..9 high (0x0200-0x1FFF), `ram_wr_n` is low exactly when `phase` is low and `rd_nwr` is low. The state of `cal_unlock` does not matter.
- R6: For RAM addresses 0x0040-0x01FF, `ram_wr_n` is low only when `phase` is low, `rd_nwr` is low and `cal_unlock` is high.
- R7: A write to ROM space never drives `ram_wr_n` low. `ram_wr_n` low always implies `ram_ce` high.
- R8: A write to 0x0040-0x01FF while `cal_unlock` is low raises `cal_violation` for exactly the one cycle after the first clock edge that samples it. The flag stays low while that write persists and re-arms once it ends. Reads and unlocked writes never raise it.
- R9: The synchronous active-high reset `rst` clears `cal_violation` by the cycle after the edge that samples it, and keeps it low while held.
- R10: `rd_n` and `ram_wr_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the violation flag |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Processor address bus |
| rd_nwr | input | 1 | 1 = read cycle, 0 = write cycle |
| phase | input | 1 | Bus clock phase |
| cal_unlock | input | 1 | Permits writes to the calibration region |
| rom_ce | output | 1 | ROM chip enable, active high |
| ram_ce | output | 1 | RAM chip enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| ram_wr_n | output | 1 | RAM write strobe, active low |
| cal_violation | output | 1 | One-cycle pulse on a blocked calibration write |

## Verification
The bench builds the decoder with its default parameters: a 16-bit address, ROM above bit 13, RAM above bit 6 and the open RAM region above bit 9. These values put every region edge within reach: 0x003F/0x0040, 0x01FF/0x0200, 0x1FFF/0x2000 and 0xFFFF. The vector table covers those edges, and a strided sweep of the whole address space compares the chip enables and the write strobe against numeric range bounds. Directed sequences then walk the guard machine through all of its transitions, including reset asserted during a blocked write.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    // Owner of the current address
    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,   // below RAM, unmapped
        RGN_CAL  = 2'd1,   // protected low RAM
        RGN_OPEN = 2'd2,   // freely writable RAM
        RGN_ROM  = 2'd3    // program store
    } region_e;

    // Violation guard states
    typedef enum logic [1:0] {
        G_IDLE = 2'd0,
        G_FLAG = 2'd1,
        G_HOLD = 2'd2
    } guard_e;

endpackage

// File: rtl/memmap_region_decode.sv
module memmap_region_decode
    import memmap_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int ROM_LSB  = 13,
    parameter int RAM_LSB  = 6,
    parameter int OPEN_LSB = 9
) (
    input  logic [ADDR_W-1:RAM_LSB] addr_hi,
    output region_e                 region
);
    localparam int RAM_MSB = ROM_LSB - 1;

    logic rom_any;
    logic ram_any;
    logic open_any;

    assign rom_any  = |addr_hi[ADDR_W-1:ROM_LSB];
    assign ram_any  = |addr_hi[RAM_MSB:RAM_LSB];
    assign open_any = |addr_hi[RAM_MSB:OPEN_LSB];

    // Priority: ROM bits win, then open RAM, then calibration RAM
    always_comb begin
        if (rom_any)       region = RGN_ROM;
        else if (open_any) region = RGN_OPEN;
        else if (ram_any)  region = RGN_CAL;
        else               region = RGN_NONE;
    end
endmodule

// File: rtl/memmap_strobe_gen.sv
module memmap_strobe_gen
    import memmap_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  region_e region,
    input  logic    rd_nwr,
    input  logic    phase,
    input  logic    cal_unlock,
    output logic    rom_ce,
    output logic    ram_ce,
    output logic    rd_n,
    output logic    ram_wr_n,
    output logic    blocked
);
    logic wr_ok;

    always_comb begin
        rom_ce = 1'b0;
        ram_ce = 1'b0;
        wr_ok  = 1'b0;
        unique case (region)
            RGN_ROM:  rom_ce = 1'b1;
            RGN_OPEN: begin
                ram_ce = 1'b1;
                wr_ok  = 1'b1;
            end
            RGN_CAL: begin
                ram_ce = 1'b1;
                wr_ok  = cal_unlock;
            end
            RGN_NONE: ;
            default: ;
        endcase
    end

    assign rd_n     = ~(phase & rd_nwr);
    assign ram_wr_n = ~(~phase & ~rd_nwr & wr_ok);
    assign blocked  = ~rd_nwr & (region == RGN_CAL) & ~cal_unlock;

    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !ram_wr_n));

    assert_wr_needs_ram_R7: assert property (@(posedge clk) disable iff (rst)
        !ram_wr_n |-> (ram_ce && !rom_ce));

    assert_blocked_no_wr_R6: assert property (@(posedge clk) disable iff (rst)
        blocked |-> ram_wr_n);
endmodule

// File: rtl/memmap_guard.sv
module memmap_guard
    import memmap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic blocked,
    output logic violation
);
    guard_e state_q;
    guard_e state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= G_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            G_IDLE: if (blocked)  state_d = G_FLAG;
            G_FLAG: state_d = blocked ? G_HOLD : G_IDLE;
            G_HOLD: if (!blocked) state_d = G_IDLE;
            default: state_d = G_IDLE;
        endcase
    end

    assign violation = (state_q == G_FLAG);

    assert_flag_single_R8: assert property (@(posedge clk) disable iff (rst)
        violation |=> !violation);

    assert_flag_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(violation) |-> $past(blocked));

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> !violation);
endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
    import memmap_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int ROM_LSB  = 13,
    parameter int RAM_LSB  = 6,
    parameter int OPEN_LSB = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_nwr,
    input  logic              phase,
    input  logic              cal_unlock,
    output logic              rom_ce,
    output logic              ram_ce,
    output logic              rd_n,
    output logic              ram_wr_n,
    output logic              cal_violation
);
    localparam logic [ADDR_W-1:0] RAM_BASE = ADDR_W'(1) << RAM_LSB;
    localparam logic [ADDR_W-1:0] ROM_BASE = ADDR_W'(1) << ROM_LSB;

    region_e region;
    logic    blocked;

    memmap_region_decode #(
        .ADDR_W  (ADDR_W),
        .ROM_LSB (ROM_LSB),
        .RAM_LSB (RAM_LSB),
        .OPEN_LSB(OPEN_LSB)
    ) u_decode (
        .addr_hi(addr[ADDR_W-1:RAM_LSB]),
        .region (region)
    );

    memmap_strobe_gen u_strobe (
        .clk       (clk),
        .rst       (rst),
        .region    (region),
        .rd_nwr    (rd_nwr),
        .phase     (phase),
        .cal_unlock(cal_unlock),
        .rom_ce    (rom_ce),
        .ram_ce    (ram_ce),
        .rd_n      (rd_n),
        .ram_wr_n  (ram_wr_n),
        .blocked   (blocked)
    );

    memmap_guard u_guard (
        .clk      (clk),
        .rst      (rst),
        .blocked  (blocked),
        .violation(cal_violation)
    );

    assert_ce_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(rom_ce && ram_ce));

    assert_low_unmapped_R3: assert property (@(posedge clk) disable iff (rst)
        (addr < RAM_BASE) |-> (!rom_ce && !ram_ce && ram_wr_n));

    assert_rom_space_R1: assert property (@(posedge clk) disable iff (rst)
        (addr >= ROM_BASE) |-> (rom_ce && ram_wr_n));
endmodule

// File: tb/memmap_decoder_tb_top.sv
module memmap_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = 16'h0000;
    logic        rd_nwr = 1'b1;
    logic        phase = 1'b0;
    logic        cal_unlock = 1'b0;
    logic        rom_ce, ram_ce, rd_n, ram_wr_n, cal_violation;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    memmap_decoder dut_i (
        .clk(clk), .rst(rst), .addr(addr), .rd_nwr(rd_nwr), .phase(phase),
        .cal_unlock(cal_unlock), .rom_ce(rom_ce), .ram_ce(ram_ce),
        .rd_n(rd_n), .ram_wr_n(ram_wr_n), .cal_violation(cal_violation)
    );

    // {addr, rd_nwr, phase, unlock, exp_rom, exp_ram, exp_rd_n, exp_wr_n}
    localparam int NV = 16;
    localparam logic [22:0] VEC [NV] = '{
        {16'h0000, 3'b110, 4'b0001},  // R3 R4
        {16'h003F, 3'b001, 4'b0011},  // R3
        {16'h0040, 3'b110, 4'b0101},  // R2 R4
        {16'h0040, 3'b000, 4'b0111},  // R6 locked
        {16'h0040, 3'b001, 4'b0110},  // R6 unlocked
        {16'h01FF, 3'b000, 4'b0111},  // R6
        {16'h01FF, 3'b001, 4'b0110},  // R6
        {16'h0200, 3'b000, 4'b0110},  // R5
        {16'h0200, 3'b010, 4'b0111},  // R5 phase high
        {16'h1FFF, 3'b000, 4'b0110},  // R5 R2
        {16'h2000, 3'b001, 4'b1011},  // R7 R1
        {16'h2000, 3'b110, 4'b1001},  // R1 R4
        {16'hFFFF, 3'b100, 4'b1011},  // R4 phase low
        {16'h8000, 3'b000, 4'b1011},  // R7
        {16'h1FFF, 3'b110, 4'b0101},  // R2 R4
        {16'h0100, 3'b110, 4'b0101}   // R2
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%b exp=%b (addr=%h rw=%b ph=%b unl=%b)",
                     req, act, exp, addr, rd_nwr, phase, cal_unlock);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog act=timeout exp=done");
        summary();
    end

    initial begin
        tick();
        tick();
        check("R9 reset", {3'b000, cal_violation}, 4'b0000);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            {addr, rd_nwr, phase, cal_unlock} = VEC[i][22:4];
            #2;
            check("R1 R2 R4 R5 R6 R7 vector", {rom_ce, ram_ce, rd_n, ram_wr_n}, VEC[i][3:0]);
            check("R10 strobes", {3'b000, (!rd_n && !ram_wr_n)}, 4'b0000);
        end

        // R1 R2 R3 R5 sweep of the space with locked writes in the low phase
        rd_nwr = 1'b0; phase = 1'b0; cal_unlock = 1'b0;
        for (int a = 0; a < 65536; a += 61) begin
            logic er, em, ew;
            addr = 16'(a);
            #2;
            er = (a >= 32'h2000);
            em = (a >= 32'h40) && (a < 32'h2000);
            ew = !((a >= 32'h200) && (a < 32'h2000));
            check("R1 R2 R3 R5 sweep", {1'b0, rom_ce, ram_ce, ram_wr_n}, {1'b0, er, em, ew});
        end

        // R8 guard sequence
        rst = 1'b1; tick(); rst = 1'b0;
        addr = 16'h0300; rd_nwr = 1'b0; cal_unlock = 1'b0;
        tick();
        check("R8 open write no flag", {3'b000, cal_violation}, 4'b0000);
        addr = 16'h0080;
        tick();
        check("R8 first pulse", {3'b000, cal_violation}, 4'b0001);
        tick();
        check("R8 held low", {3'b000, cal_violation}, 4'b0000);
        tick();
        check("R8 still held", {3'b000, cal_violation}, 4'b0000);
        addr = 16'h0300;
        tick();
        check("R8 release", {3'b000, cal_violation}, 4'b0000);
        addr = 16'h01FF;
        tick();
        check("R8 re-armed pulse", {3'b000, cal_violation}, 4'b0001);
        cal_unlock = 1'b1;
        tick();
        tick();
        check("R6 R8 unlocked no flag", {3'b000, cal_violation}, 4'b0000);
        cal_unlock = 1'b0; rd_nwr = 1'b1;
        tick();
        check("R8 read no flag", {3'b000, cal_violation}, 4'b0000);
        addr = 16'h2040; rd_nwr = 1'b0;
        tick();
        check("R7 R8 rom write no flag", {3'b000, cal_violation}, 4'b0000);

        // R9 reset during a blocked write
        addr = 16'h0040; rst = 1'b1;
        tick();
        check("R9 reset holds low", {3'b000, cal_violation}, 4'b0000);
        tick();
        check("R9 reset still low", {3'b000, cal_violation}, 4'b0000);
        rst = 1'b0;
        tick();
        check("R8 R9 pulse after reset", {3'b000, cal_violation}, 4'b0001);
        tick();
        check("R8 single cycle", {3'b000, cal_violation}, 4'b0000);

        summary();
    end
endmodule